// File: doc/BRIEF.md
# STS-1 Column Time-Slot Interchange

This block regroups a byte-interleaved stream made of twelve STS-1-equivalent columns. The stream is four STS-3 channels interleaved on one byte-wide bus, so a round of twelve consecutive valid bytes carries one byte from each column. A frame sync marker flags the byte of column 0 that opens a frame. A connection map holds one entry per output time slot. Each entry names the input column that feeds that slot, and the column can come from any channel. One column may feed several slots (broadcast), and columns may be exchanged (swap). The block never looks inside the payload bytes, so the payload mapping carried in the columns has no effect on it.

Incoming bytes are written into one page of a two-page, twelve-byte store while the other page is read through the map. Output slot s of round k therefore carries column map[s] of round k-1. Every output byte appears one clock after the input byte that occupies the same slot position. New map entries go into a shadow copy. The shadow copy becomes the active map only on the next frame sync byte, so a frame is never groomed with a half-written map. The same block serves both the add direction and the drop direction.

A three-state controller sequences the store. **HUNT** is the state after reset. It ignores all bytes and leaves the map switch pending. The transition *sync-found* (a valid byte with sync in HUNT) leads to **PAGE0**. The transition *round-done-0* (column 11 written in PAGE0) leads to **PAGE1**. The transition *round-done-1* (column 11 written in PAGE1) leads back to **PAGE0**. The state name tells which page is being written. The other page is the one being read.

Top module: `col_tsi`

## Requirements
- R1: The column index is 0 on a valid byte with `in_sync` high. On any other accepted valid byte it is the previous index plus one, modulo 12. Cycles with `in_valid` low leave the index unchanged.
- R2: An output byte of slot s carries the byte that the previous round held in column map[s]. Here map[s] is the 4-bit entry s of the active map. The output byte appears on the clock after the input byte of slot s.
- R3: Map entries may repeat a column, which broadcasts it to several slots, and may exchange columns (swap). Each slot still receives its own selected byte.
- R4: `map_wr_en` writes `map_wr_data` into shadow entry `map_wr_addr`. The shadow copy is loaded into the active map on an accepted sync byte. That sync byte's own slot already uses the new map. A shadow write in the same cycle as the sync byte does not take part in that load.
- R5: An active map entry with a value from 12 to 15 outputs the byte 0xFF in its slot.
- R6: A map write with `map_wr_addr` from 12 to 15 changes no entry.
- R7: From reset until the first valid byte with `in_sync` high, bytes are not stored and `out_valid` stays low.
- R8: `out_sync` and `out_marker` repeat `in_sync` and `in_marker` of an accepted byte one clock later, aligned with `out_valid`.
- R9: `out_data` is 0x00 whenever `out_valid` is low.
- R10: Reset clears every stored byte to 0x00 and sets both the shadow map and the active map to identity (slot s takes column s). Reset also drives all outputs low.
- R11: A sync byte that arrives in the middle of a round restarts the index at 0 without switching pages. Pages switch only after column 11 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Input payload byte |
| in_sync | input | 1 | Frame sync, marks a column 0 byte |
| in_marker | input | 1 | Positional marker passed through with the byte slot |
| map_wr_en | input | 1 | Write one shadow map entry |
| map_wr_addr | input | 4 | Output slot whose entry is written |
| map_wr_data | input | 4 | Input column selected for that slot |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Groomed payload byte |
| out_sync | output | 1 | Forwarded frame sync |
| out_marker | output | 1 | Forwarded marker |

## Verification
The bench builds the block with its default values: twelve columns and 8-bit bytes. With these values a full round and both page roles come around within a few dozen cycles, so hundreds of page swaps and map switches fit in a short run. The 4-bit map field leaves four spare codes (12 to 15), so the 0xFF fill and the ignored out-of-range map writes can be reached with ordinary stimulus. The bench also inserts random idle gaps and a sync in the middle of a round.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // Page controller states. The state name tells which page is being written.
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_PAGE0 = 2'd1,
        ST_PAGE1 = 2'd2
    } tsi_state_e;

endpackage

// File: rtl/tsi_col_fsm.sv
module tsi_col_fsm
    import tsi_pkg::*;
#(
    parameter int NUM_COLS = 12,
    localparam int COL_W   = $clog2(NUM_COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sync,
    output logic             accept,
    output logic             frame_start,
    output logic [COL_W-1:0] col_idx,
    output logic             wr_page,
    output logic             hunting
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    tsi_state_e       state_q, state_d;
    logic [COL_W-1:0] cnt_q;
    logic             last_col;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // column counter, advances only on accepted bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= last_col ? '0 : col_idx + COL_W'(1);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (in_valid && in_sync) state_d = ST_PAGE0;
            end
            ST_PAGE0: begin
                if (accept && last_col) state_d = ST_PAGE1;
            end
            ST_PAGE1: begin
                if (accept && last_col) state_d = ST_PAGE0;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        hunting     = 1'b0;
        wr_page     = 1'b0;
        accept      = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                hunting = 1'b1;
                accept  = in_valid && in_sync;
            end
            ST_PAGE0: begin
                accept  = in_valid;
            end
            ST_PAGE1: begin
                wr_page = 1'b1;
                accept  = in_valid;
            end
            default: begin
                hunting = 1'b1;
            end
        endcase
        col_idx     = in_sync ? '0 : cnt_q;
        last_col    = (col_idx == LAST_COL);
        frame_start = accept && in_sync;
    end

endmodule

// File: rtl/tsi_conn_map.sv
module tsi_conn_map #(
    parameter int NUM_COLS = 12,
    localparam int SEL_W   = $clog2(NUM_COLS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      map_wr_en,
    input  logic [SEL_W-1:0]          map_wr_addr,
    input  logic [SEL_W-1:0]          map_wr_data,
    input  logic                      frame_start,
    output logic [NUM_COLS*SEL_W-1:0] eff_map
);

    genvar g;
    generate
        for (g = 0; g < NUM_COLS; g++) begin : g_entry
            logic [SEL_W-1:0] shadow_q;
            logic [SEL_W-1:0] active_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shadow_q <= SEL_W'(g);
                end else if (map_wr_en && (map_wr_addr == SEL_W'(g))) begin
                    shadow_q <= map_wr_data;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    active_q <= SEL_W'(g);
                end else if (frame_start) begin
                    active_q <= shadow_q;
                end
            end

            // the sync byte itself is read through the incoming map
            assign eff_map[g*SEL_W +: SEL_W] = frame_start ? shadow_q : active_q;
        end
    endgenerate

endmodule

// File: rtl/tsi_page_store.sv
module tsi_page_store #(
    parameter int NUM_COLS = 12,
    parameter int DATA_W   = 8,
    localparam int SEL_W   = $clog2(NUM_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_page,
    input  logic [SEL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_page,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] page0 [NUM_COLS];
    logic [DATA_W-1:0] page1 [NUM_COLS];
    logic              sel_ok;

    genvar g;
    generate
        for (g = 0; g < NUM_COLS; g++) begin : g_cell
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    page0[g] <= '0;
                    page1[g] <= '0;
                end else if (wr_en && (wr_col == SEL_W'(g))) begin
                    if (wr_page) page1[g] <= wr_data;
                    else         page0[g] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        sel_ok  = (rd_sel < SEL_W'(NUM_COLS));
        rd_data = '1;
        if (sel_ok) begin
            rd_data = rd_page ? page1[rd_sel] : page0[rd_sel];
        end
    end

endmodule

// File: rtl/col_tsi.sv
module col_tsi #(
    parameter int NUM_COLS = 12,
    parameter int DATA_W   = 8,
    localparam int SEL_W   = $clog2(NUM_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sync,
    input  logic              in_marker,
    input  logic              map_wr_en,
    input  logic [SEL_W-1:0]  map_wr_addr,
    input  logic [SEL_W-1:0]  map_wr_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sync,
    output logic              out_marker
);

    logic                      accept;
    logic                      frame_start;
    logic [SEL_W-1:0]          col_idx;
    logic                      wr_page;
    logic                      hunting;
    logic [NUM_COLS*SEL_W-1:0] eff_map;
    logic [SEL_W-1:0]          slot_sel;
    logic [DATA_W-1:0]         rd_data;

    tsi_col_fsm #(.NUM_COLS(NUM_COLS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sync     (in_sync),
        .accept      (accept),
        .frame_start (frame_start),
        .col_idx     (col_idx),
        .wr_page     (wr_page),
        .hunting     (hunting)
    );

    tsi_conn_map #(.NUM_COLS(NUM_COLS)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .map_wr_en   (map_wr_en),
        .map_wr_addr (map_wr_addr),
        .map_wr_data (map_wr_data),
        .frame_start (frame_start),
        .eff_map     (eff_map)
    );

    always_comb begin
        slot_sel = '0;
        for (int s = 0; s < NUM_COLS; s++) begin
            if (col_idx == SEL_W'(s)) slot_sel = eff_map[s*SEL_W +: SEL_W];
        end
    end

    tsi_page_store #(.NUM_COLS(NUM_COLS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_page (wr_page),
        .wr_col  (col_idx),
        .wr_data (in_data),
        .rd_page (~wr_page),
        .rd_sel  (slot_sel),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_sync   <= 1'b0;
            out_marker <= 1'b0;
        end else begin
            out_valid  <= accept;
            out_data   <= accept ? rd_data : '0;
            out_sync   <= accept && in_sync;
            out_marker <= accept && in_marker;
        end
    end

endmodule

// File: rtl/col_tsi_chk.sv
module col_tsi_chk #(
    parameter int NUM_COLS = 12,
    parameter int DATA_W   = 8,
    localparam int SEL_W   = $clog2(NUM_COLS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sync,
    input logic              hunting,
    input logic [SEL_W-1:0]  col_idx,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sync,
    input logic              out_marker
);

    p_col_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        col_idx < SEL_W'(NUM_COLS));

    p_idle_no_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hunt_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && !(in_valid && in_sync)) |=> !out_valid);

    p_sync_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync) |=> (out_valid && out_sync));

    p_side_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sync || out_marker) |-> out_valid);

    p_quiet_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));

endmodule

bind col_tsi col_tsi_chk #(.NUM_COLS(NUM_COLS), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sync    (in_sync),
    .hunting    (hunting),
    .col_idx    (col_idx),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_sync   (out_sync),
    .out_marker (out_marker)
);

// File: tb/test_col_tsi.sv
module test_col_tsi;

    localparam int N = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sync = 1'b0;
    logic       in_marker = 1'b0;
    logic       map_wr_en = 1'b0;
    logic [3:0] map_wr_addr = '0;
    logic [3:0] map_wr_data = '0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sync;
    logic       out_marker;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string phase = "R10";

    always #5 clk = ~clk;

    col_tsi i_col_tsi (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sync(in_sync), .in_marker(in_marker), .map_wr_en(map_wr_en),
        .map_wr_addr(map_wr_addr), .map_wr_data(map_wr_data),
        .out_valid(out_valid), .out_data(out_data), .out_sync(out_sync),
        .out_marker(out_marker)
    );

    // behavioural reference
    bit   m_hunt;
    bit   m_wp;
    int   m_cnt;
    int   m_mem [2][N];
    int   m_act [N];
    int   m_shd [N];
    bit   e_valid, e_sync, e_mark;
    int   e_data;
    string e_tag = "R10";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hunt = 1; m_wp = 0; m_cnt = 0;
            for (int i = 0; i < N; i++) begin
                m_mem[0][i] = 0; m_mem[1][i] = 0; m_act[i] = i; m_shd[i] = i;
            end
            e_valid = 0; e_sync = 0; e_mark = 0; e_data = 0; e_tag = "R10";
        end else begin
            e_valid = 0; e_sync = 0; e_mark = 0; e_data = 0; e_tag = "R7/R9";
            if (in_valid && (!m_hunt || in_sync)) begin
                int col, sel;
                col = in_sync ? 0 : m_cnt;
                sel = in_sync ? m_shd[col] : m_act[col];
                e_data  = (sel >= N) ? 8'hFF : m_mem[!m_wp][sel];
                e_valid = 1; e_sync = in_sync; e_mark = in_marker;
                e_tag = (sel >= N) ? "R5" : (in_sync ? "R4/R8" : "R2/R3");
                m_mem[m_wp][col] = in_data;
                if (in_sync) for (int i = 0; i < N; i++) m_act[i] = m_shd[i];
                if (col == N - 1) begin m_cnt = 0; m_wp = !m_wp; end
                else m_cnt = col + 1;
                m_hunt = 0;
            end
            if (map_wr_en && map_wr_addr < N) m_shd[map_wr_addr] = map_wr_addr == map_wr_addr ? map_wr_data : 0;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (out_valid !== e_valid || out_sync !== e_sync || out_marker !== e_mark ||
                out_data !== 8'(e_data)) begin
                fails++;
                $display("FAIL %s (%s): got v=%0b d=%02h s=%0b m=%0b expected v=%0b d=%02h s=%0b m=%0b",
                         e_tag, phase, out_valid, out_data, out_sync, out_marker,
                         e_valid, 8'(e_data), e_sync, e_mark);
            end
        end
    end

    task automatic cyc(input bit v, input bit s, input bit m,
                       input bit we = 0, input int wa = 0, input int wd = 0);
        @(negedge clk);
        in_valid = v; in_data = v ? 8'($urandom) : 8'h00; in_sync = s; in_marker = m;
        map_wr_en = we; map_wr_addr = 4'(wa); map_wr_data = 4'(wd);
    endtask

    // one frame of several rounds, optional random idle gaps
    task automatic frame(input int rounds, input bit gaps);
        for (int r = 0; r < rounds; r++) begin
            for (int c = 0; c < N; c++) begin
                if (gaps && ($urandom % 4 == 0)) cyc(0, 0, 0);
                cyc(1, (r == 0 && c == 0), (c % 3 == 1));
            end
        end
    endtask

    task automatic set_map(input int m [N]);
        for (int i = 0; i < N; i++) cyc(0, 0, 0, 1, i, m[i]);
    endtask

    initial begin
        int mp [N];
        repeat (3) @(negedge clk);
        // R10: reset state
        phase = "R10";
        checks++;
        if (out_valid !== 0 || out_data !== 0 || out_sync !== 0 || out_marker !== 0) begin
            fails++;
            $display("FAIL R10: outputs %0b %02h %0b %0b expected all zero",
                     out_valid, out_data, out_sync, out_marker);
        end
        rst_n = 1'b1;
        // R7: bytes before first sync are dropped
        phase = "R7";
        for (int i = 0; i < 20; i++) cyc(1, 0, 1);
        // R10/R1: identity map, first round reads zero page
        phase = "R1/R10";
        frame(3, 0);
        frame(3, 1);
        // R3: swap and broadcast
        phase = "R3";
        for (int i = 0; i < N; i++) mp[i] = N - 1 - i;
        set_map(mp);
        frame(3, 1);
        for (int i = 0; i < N; i++) mp[i] = (i < 6) ? 4 : 9;
        set_map(mp);
        frame(3, 1);
        // R4: shadow write in same cycle as sync is not loaded until next sync
        phase = "R4";
        cyc(1, 1, 0, 1, 0, 7);
        for (int c = 1; c < N; c++) cyc(1, 0, 0);
        frame(2, 0);
        frame(2, 0);
        // R5: invalid entries fill 0xFF
        phase = "R5";
        for (int i = 0; i < N; i++) mp[i] = (i % 3 == 0) ? 12 + (i % 4) : i;
        set_map(mp);
        frame(3, 1);
        // R6: out-of-range map addresses ignored
        phase = "R6";
        for (int a = 12; a < 16; a++) cyc(0, 0, 0, 1, a, 13);
        for (int i = 0; i < N; i++) mp[i] = (i * 5) % N;
        set_map(mp);
        frame(3, 1);
        // R11: sync in the middle of a round
        phase = "R11";
        for (int c = 0; c < 5; c++) cyc(1, (c == 0), 0);
        frame(3, 0);
        for (int c = 0; c < 7; c++) cyc(1, (c == 0), 1);
        frame(3, 1);
        // R2/R8: long random run with random map changes
        phase = "R2/R8";
        for (int k = 0; k < 60; k++) begin
            cyc(0, 0, 0, 1, $urandom % 16, $urandom % 16);
            frame(1 + $urandom % 3, 1);
        end
        cyc(0, 0, 0);
        cyc(0, 0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule